// File: doc/BRIEF.md
# SHA-1 Message Schedule Expander, Four Words per Cycle

This block turns one 512-bit message block into the eighty constant-adjusted schedule words that a SHA-1 round engine consumes. It emits them four at a time as twenty groups. Each group carries the words W(t)+K(t) for four consecutive indices t. The block is fed sixteen 32-bit words whose bytes arrive in little-endian order. It reverses the bytes of each word, passes the first sixteen words straight through, and then generates the rest from a 32-word history.

The indices 16 to 31 use the one-step recurrence. In that range the fourth word of a group depends on the first word of the same group. The block first computes the fourth word with a zero standing in for that first word, then folds in the first word's term as a rotate by two of the first word's pre-rotate value. From index 32 onward a distance-32 form of the recurrence is used, in which all four words of a group are independent of one another. Padding, the compression rounds and the chaining-value update belong to neighbouring blocks.

The control is a two-state machine. ST_IDLE offers `in_ready`. The transition ACCEPT (IDLE to EMIT) fires when `in_valid` is seen high. ST_EMIT presents groups on the output. In EMIT, NEXT (EMIT to EMIT) fires on each handoff of groups 0 to 18, and DONE (EMIT to IDLE) fires on the handoff of group 19. STALL keeps EMIT unchanged while `out_ready` is low.

Top module: `sha1x_sched`

## Requirements
- R1: Input word i sits at `in_block[32i+31:32i]`, and its bytes are reversed before use: bits 7:0 become bits 31:24 of the schedule word, and so on.
- R2: Groups 0 to 3 carry the byte-reversed input words 0 to 15, each with the round constant added.
- R3: Words 16 to 31 equal ROL1(W(t-3)^W(t-8)^W(t-14)^W(t-16)). This includes the fourth word of each group, which depends on the first word of the same group.
- R4: Words 32 to 79 equal the same one-step recurrence. The block computes them as ROL2(W(t-6)^W(t-16)^W(t-28)^W(t-32)).
- R5: The constant added modulo 2^32 is 0x5A827999 for t 0–19, 0x6ED9EBA1 for t 20–39, 0x8F1BBCDC for t 40–59 and 0xCA62C1D6 for t 60–79.
- R6: Each block yields exactly 20 groups. Lane j of group g, at `out_data[32j+31:32j]`, carries word 4g+j. `out_last` is high only with group 19.
- R7: While `out_valid` is high and `out_ready` is low, the offered group, `out_last` and the internal state stay unchanged.
- R8: `in_ready` is high only when no group is pending. `in_valid` has no effect while groups are being emitted, and a new block is taken only after group 19 has been handed off.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message block is offered |
| in_ready | output | 1 | Block can be taken (idle) |
| in_block | input | 512 | Sixteen words, little-endian bytes |
| out_valid | output | 1 | A group is offered |
| out_ready | input | 1 | Downstream takes the group |
| out_data | output | 128 | Four words W(t)+K(t), lane 0 lowest |
| out_last | output | 1 | Offered group is group 19 |

## Verification
A corrupt history word does not show up until the group that reads it. A wrong entry at distance 32, 28 or 16 therefore surfaces between one and eight groups later, while a bad newest group already affects the next group's fourth lane. For that reason every lane of all twenty groups is compared against a single-step reference, under steady, alternating and irregular backpressure. A wrong group counter or a wrong state shows within one handoff, as a misplaced `out_last`, as a wrong constant at the 19/20, 39/40 and 59/60 boundaries, or as `in_ready` rising while groups remain.

// File: rtl/sha1x_pkg.sv
package sha1x_pkg;
    localparam int WORD_W       = 32;
    localparam int LANES        = 4;
    localparam int IN_WORDS     = 16;
    localparam int HIST_WORDS   = 32;
    localparam int TOTAL_WORDS  = 80;
    localparam int NUM_GROUPS   = TOTAL_WORDS / LANES;
    localparam int GROUPS_PER_K = 20 / LANES;
    localparam int GRP_W        = $clog2(NUM_GROUPS);
    localparam int SEED_GROUPS  = IN_WORDS / LANES;
    localparam int LONG_GROUP   = HIST_WORDS / LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic {ST_IDLE, ST_EMIT} sched_state_e;

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t round_const(input logic [GRP_W-1:0] grp);
        int unsigned band;
        band = int'(grp) / GROUPS_PER_K;
        unique case (band)
            0:       return 32'h5A827999;
            1:       return 32'h6ED9EBA1;
            2:       return 32'h8F1BBCDC;
            default: return 32'hCA62C1D6;
        endcase
    endfunction
endpackage

// File: rtl/sched_bswap.sv
module sched_bswap
    import sha1x_pkg::*;
#(
    parameter int N_WORDS = IN_WORDS
) (
    input  logic [N_WORDS*WORD_W-1:0] raw,
    output logic [N_WORDS*WORD_W-1:0] swapped
);
    localparam int BYTES = WORD_W / 8;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign swapped[w*WORD_W + (BYTES-1-b)*8 +: 8] = raw[w*WORD_W + b*8 +: 8];
        end
    end
endmodule

// File: rtl/sched_wordgen.sv
module sched_wordgen
    import sha1x_pkg::*;
(
    input  logic [HIST_WORDS*WORD_W-1:0] win,
    input  logic                         use_long,
    output logic [LANES*WORD_W-1:0]      grp
);
    // win word k holds W(t-32+k); age d maps to word HIST_WORDS-d
    word_t part  [LANES];
    word_t longw [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int D3 = 3 - j;
        if (D3 > 0) begin : g_known
            assign part[j] = win[(HIST_WORDS-D3)*WORD_W +: WORD_W]
                           ^ win[(HIST_WORDS-8+j)*WORD_W +: WORD_W]
                           ^ win[(HIST_WORDS-14+j)*WORD_W +: WORD_W]
                           ^ win[(HIST_WORDS-16+j)*WORD_W +: WORD_W];
        end else begin : g_zero_fill
            assign part[j] = win[(HIST_WORDS-8+j)*WORD_W +: WORD_W]
                           ^ win[(HIST_WORDS-14+j)*WORD_W +: WORD_W]
                           ^ win[(HIST_WORDS-16+j)*WORD_W +: WORD_W];
        end

        assign longw[j] = rotl(win[(HIST_WORDS-6+j)*WORD_W +: WORD_W]
                             ^ win[(HIST_WORDS-16+j)*WORD_W +: WORD_W]
                             ^ win[(HIST_WORDS-28+j)*WORD_W +: WORD_W]
                             ^ win[j*WORD_W +: WORD_W], 2);

        if (D3 > 0) begin : g_plain
            assign grp[j*WORD_W +: WORD_W] = use_long ? longw[j] : rotl(part[j], 1);
        end else begin : g_fixup
            assign grp[j*WORD_W +: WORD_W] = use_long ? longw[j]
                                           : (rotl(part[j], 1) ^ rotl(part[0], 2));
        end
    end
endmodule

// File: rtl/sched_kadd.sv
module sched_kadd
    import sha1x_pkg::*;
(
    input  logic [LANES*WORD_W-1:0] words,
    input  logic [GRP_W-1:0]        grp_idx,
    output logic [LANES*WORD_W-1:0] sums
);
    word_t kval;
    assign kval = round_const(grp_idx);

    for (genvar j = 0; j < LANES; j++) begin : g_add
        assign sums[j*WORD_W +: WORD_W] = words[j*WORD_W +: WORD_W] + kval;
    end
endmodule

// File: rtl/sha1x_sched.sv
module sha1x_sched
    import sha1x_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [IN_WORDS*WORD_W-1:0]   in_block,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [LANES*WORD_W-1:0]      out_data,
    output logic                         out_last
);
    localparam int GRP_BITS  = LANES * WORD_W;
    localparam int HIST_BITS = HIST_WORDS * WORD_W;
    localparam int SEED_BITS = (IN_WORDS - LANES) * WORD_W;
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

    sched_state_e           state_q, state_d;
    logic [GRP_W-1:0]       grp_q;
    logic [GRP_BITS-1:0]    cur_q;
    logic [SEED_BITS-1:0]   seed_q;
    logic [HIST_BITS-1:0]   hist_q;

    logic [IN_WORDS*WORD_W-1:0] swapped;
    logic [HIST_BITS-1:0]       win_next;
    logic [GRP_BITS-1:0]        gen_grp;
    logic [GRP_W-1:0]           grp_inc;
    logic                       accept, handoff, use_long;

    sched_bswap #(.N_WORDS(IN_WORDS)) u_bswap (
        .raw     (in_block),
        .swapped (swapped)
    );

    assign win_next = {cur_q, hist_q[HIST_BITS-1:GRP_BITS]};
    assign grp_inc  = grp_q + 1'b1;
    assign use_long = int'(grp_inc) >= LONG_GROUP;

    sched_wordgen u_gen (
        .win      (win_next),
        .use_long (use_long),
        .grp      (gen_grp)
    );

    sched_kadd u_kadd (
        .words   (cur_q),
        .grp_idx (grp_q),
        .sums    (out_data)
    );

    assign accept  = in_valid && in_ready;
    assign handoff = out_valid && out_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: if (out_ready && grp_q == LAST_GRP) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                grp_q <= '0;
            else if (handoff && grp_q != LAST_GRP)
                grp_q <= grp_inc;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (accept) begin
            cur_q  <= swapped[GRP_BITS-1:0];
            seed_q <= swapped[IN_WORDS*WORD_W-1:GRP_BITS];
            hist_q <= '0;
        end else if (handoff && grp_q != LAST_GRP) begin
            hist_q <= win_next;
            cur_q  <= (int'(grp_inc) < SEED_GROUPS) ? seed_q[GRP_BITS-1:0] : gen_grp;
            seed_q <= {{GRP_BITS{1'b0}}, seed_q[SEED_BITS-1:GRP_BITS]};
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_last  = (state_q == ST_EMIT) && (grp_q == LAST_GRP);
    end
endmodule

// File: rtl/sha1x_sched_checker.sv
module sha1x_sched_checker
    import sha1x_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*WORD_W-1:0] out_data,
    input logic                    out_last
);
    logic [GRP_W-1:0] sent_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sent_q <= '0;
        else if (out_valid && out_ready)
            sent_q <= out_last ? '0 : sent_q + 1'b1;
    end

    assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_start_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    assert_last_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (int'(sent_q) == NUM_GROUPS - 1)));

    assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> in_ready);
endmodule

bind sha1x_sched sha1x_sched_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/sha1x_sched_test.sv
module sha1x_sched_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_block = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic         out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int grp = 0;
    int blocks_done = 0;
    int ready_mode = 0;
    bit running = 0;
    bit prev_stall = 0;
    logic [127:0] prev_data;
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [31:0] ref_w [80];

    always #2 clk = ~clk;

    sha1x_sched uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] kc(input int t);
        if (t < 20) return 32'h5A827999;
        if (t < 40) return 32'h6ED9EBA1;
        if (t < 60) return 32'h8F1BBCDC;
        return 32'hCA62C1D6;
    endfunction

    task automatic build_ref(input logic [511:0] blk);
        for (int i = 0; i < 16; i++)
            ref_w[i] = {blk[32*i +: 8], blk[32*i+8 +: 8], blk[32*i+16 +: 8], blk[32*i+24 +: 8]};
        for (int t = 16; t < 80; t++)
            ref_w[t] = rl(ref_w[t-3] ^ ref_w[t-8] ^ ref_w[t-14] ^ ref_w[t-16], 1);
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            cycles++;
            if (cycles > 50000) begin
                check(1'b0, "watchdog", 128'(cycles), 128'd50000);
                finish_run();
            end
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R7", out_data, prev_data);
            if (out_valid) begin
                check(!in_ready, "R8", 128'(in_ready), 128'd0);
                for (int j = 0; j < 4; j++) begin
                    int t;
                    logic [31:0] e;
                    string tag;
                    t = 4 * grp + j;
                    e = ref_w[t] + kc(t);
                    if (t == 19 || t == 20 || t == 39 || t == 40 || t == 59 || t == 60) tag = "R5";
                    else if (t < 4) tag = "R1";
                    else if (t < 16) tag = "R2";
                    else if (t < 32) tag = "R3";
                    else tag = "R4";
                    check(out_data[32*j +: 32] == e, tag, 128'(out_data[32*j +: 32]), 128'(e));
                end
                check(out_last == (grp == 19), "R6", 128'(out_last), 128'(grp == 19));
            end else begin
                check(in_ready, "R8", 128'(in_ready), 128'd1);
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = cycles[0];
                default: out_ready = lfsr[3] & lfsr[7] | lfsr[11];
            endcase
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (grp == 19) begin
                    grp = 0;
                    blocks_done++;
                end else grp++;
            end
        end
    end

    task automatic run_block(input logic [511:0] blk, input int mode, input bit junk);
        int target;
        target = blocks_done + 1;
        build_ref(blk);
        ready_mode = mode;
        @(negedge clk);
        in_block = blk;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        if (junk) begin
            in_block = ~blk;
            repeat (30) @(negedge clk);
        end
        in_valid = 1'b0;
        while (blocks_done < target) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            check(!out_valid, "R8", 128'(out_valid), 128'd0);
        end
    endtask

    initial begin
        logic [511:0] blk;
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R9", 128'({out_valid, in_ready}), 128'b01);
        rst_n = 1'b1;
        running = 1;

        // "abc" padded block, bytes in memory order
        blk = '0;
        blk[7:0] = 8'h61; blk[15:8] = 8'h62; blk[23:16] = 8'h63; blk[31:24] = 8'h80;
        blk[511:504] = 8'h18;
        run_block(blk, 0, 0);

        for (int n = 0; n < 64; n++) blk[8*n +: 8] = 8'(n * 37 + 11);
        run_block(blk, 1, 1);

        run_block({512{1'b1}}, 2, 0);

        for (int n = 0; n < 16; n++) blk[32*n +: 32] = 32'h9E3779B9 * (n + 3) ^ (32'h1 << n);
        run_block(blk, 2, 1);

        run_block('0, 1, 0);
        finish_run();
    end
endmodule